// File: doc/BRIEF.md
# Distributed Arithmetic Dot-Product Engine

This block forms the weighted sum of several signed fixed-point inputs against a set of constant coefficients without using a single multiplier. The coefficients are fixed when the design is elaborated. From them the block builds a small lookup table whose address is one bit taken from every input at the same bit position. That bit position is called a slice. The table entry for a slice is the sum of the coefficients whose input bit is set.

A `start` pulse loads all inputs in parallel into per-input shift registers. The block then reads one slice per clock, most significant bit first, and folds each table value into an accumulator: it doubles the running sum and then adds the new term. After one step per input bit, it writes the finished dot product into a result register and raises `done` for one cycle.

A parameter selects a variant with a table of half the size. This variant stores offset-coded sums, which are sums of ±A. When the bit from input 0 is 1, the other address bits are inverted and the term is subtracted. A constant correction at the final step turns the accumulated value back into the exact dot product.

Top module: `da_dot_engine`

## Requirements
- R1: While `rst` is high at a clock edge, `busy`, `done` and `result` are 0 in the following cycle.
- R2: With `HALF_TABLE`=0, `result` equals Σ A_k·x_k exactly. Lane k of `x_in` is bits [k·XW +: XW] and is read as two's complement. Coefficient k is bits [k·CW +: CW] of `COEFS`, also signed. The table has 2^NUM_IN entries, and the term from the sign-bit slice is subtracted.
- R3: With `HALF_TABLE`=1, `result` equals the same exact dot product, using a table of 2^(NUM_IN-1) entries.
- R4: A `start` sampled high while the block is idle loads `x_in`, and `busy` is high in the next cycle.
- R5: `done` rises exactly XW clock edges after the edge that accepted `start`, lasts exactly one cycle, and coincides with `busy` falling.
- R6: A `start` or a change of `x_in` while `busy` is high is ignored. The running operation completes at its normal time with the result of the operands it loaded.
- R7: `result` changes only in the cycle in which `done` is high. Between completions it holds its value whatever `x_in` and `start` do while idle.
- R8: Extreme operands are computed without wrap-around in both table variants. These are all lanes at -2^(XW-1), all lanes at 2^(XW-1)-1, and mixtures of the two.
- R9: Every operation keeps `busy` high for exactly XW cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Launch request, accepted only while idle |
| x_in | input | NUM_IN*XW | Packed signed operands, lane k at [k*XW +: XW] |
| busy | output | 1 | High while slices are being accumulated |
| done | output | 1 | One-cycle completion pulse |
| result | output | CW+XW+clog2(NUM_IN) | Signed dot product, held between completions |

## Verification
Every cycle, the assertions check the control contract: the reset state, launch on an idle `start`, the single-cycle `done` that coincides with the end of `busy`, a run length of exactly XW cycles measured by a counter, and a `result` that holds except at completion. Only the bench scenarios can show that the numbers are right. These scenarios include a full sweep of input 0 against fixed other lanes, random operand sets, and the extreme-value corners, all run through the plain and the halved table side by side. The bench also shows that operands presented mid-run are ignored, which the assertions cannot observe.

// File: rtl/da_dot_pkg.sv
package da_dot_pkg;

    typedef enum logic [0:0] {
        ST_IDLE = 1'b0,
        ST_RUN  = 1'b1
    } da_state_e;

    // Per-step control produced by the sequencer
    typedef struct packed {
        logic valid;   // a slice is consumed this cycle
        logic first;   // sign-bit slice (MSB)
        logic last;    // LSB slice, result is written
    } step_ctl_t;

    // Sign-extend the low w bits of a field into an int
    function automatic int lane_value(input logic [63:0] bits, input int w);
        int v;
        v = int'(bits[31:0]);
        return (v <<< (32 - w)) >>> (32 - w);
    endfunction

    function automatic int min1(input int v);
        return (v < 1) ? 1 : v;
    endfunction

endpackage

// File: rtl/da_step_seq.sv
module da_step_seq
    import da_dot_pkg::*;
#(
    parameter int XW = 8
) (
    input  logic      clk,
    input  logic      rst,
    input  logic      start,
    output logic      load,
    output logic      busy,
    output step_ctl_t ctl
);
    localparam int CNTW = min1($clog2(XW));

    da_state_e       state_q;
    logic [CNTW-1:0] cnt_q;

    always_comb begin
        load      = (state_q == ST_IDLE) && start;
        busy      = (state_q == ST_RUN);
        ctl.valid = busy;
        ctl.first = busy && (cnt_q == '0);
        ctl.last  = busy && (cnt_q == CNTW'(XW - 1));
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= ST_IDLE;
            cnt_q   <= '0;
        end else begin
            unique case (state_q)
                ST_IDLE: begin
                    cnt_q <= '0;
                    if (start) state_q <= ST_RUN;
                end
                ST_RUN: begin
                    cnt_q <= cnt_q + 1'b1;
                    if (ctl.last) state_q <= ST_IDLE;
                end
                default: state_q <= ST_IDLE;
            endcase
        end
    end

endmodule

// File: rtl/da_bit_slicer.sv
module da_bit_slicer #(
    parameter int NUM_IN = 4,
    parameter int XW     = 8
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 load,
    input  logic                 shift,
    input  logic [NUM_IN*XW-1:0] x_in,
    output logic [NUM_IN-1:0]    slice
);
    for (genvar k = 0; k < NUM_IN; k++) begin : g_lane
        logic [XW-1:0] sr_q;

        always_ff @(posedge clk) begin
            if (rst)        sr_q <= '0;
            else if (load)  sr_q <= x_in[k*XW +: XW];
            else if (shift) sr_q <= {sr_q[XW-2:0], 1'b0};
        end

        // MSB-first: the top bit is the current slice bit of lane k
        assign slice[k] = sr_q[XW-1];
    end

endmodule

// File: rtl/da_coef_rom.sv
module da_coef_rom
    import da_dot_pkg::*;
#(
    parameter int                   NUM_IN     = 4,
    parameter int                   CW         = 8,
    parameter int                   TW         = 11,
    parameter bit                   HALF_TABLE = 1'b0,
    parameter logic [NUM_IN*CW-1:0] COEFS      = '0,
    localparam int                  ADDRW      = HALF_TABLE ? NUM_IN - 1 : NUM_IN
) (
    input  logic [ADDRW-1:0]     addr,
    output logic signed [TW-1:0] value
);
    localparam int DEPTH = 1 << ADDRW;

    // Plain: sum of A_k with bit k set.
    // Halved: sum of +/-A_k, lane 0 fixed at 0, lanes 1.. from addr.
    function automatic int entry_value(input int a);
        int acc;
        int c;
        acc = 0;
        for (int k = 0; k < NUM_IN; k++) begin
            c = lane_value(64'(COEFS >> (k * CW)), CW);
            if (HALF_TABLE) begin
                if (k == 0)                    acc -= c;
                else if (((a >> (k - 1)) & 1) != 0) acc += c;
                else                           acc -= c;
            end else if (((a >> k) & 1) != 0) begin
                acc += c;
            end
        end
        return acc;
    endfunction

    logic signed [TW-1:0] table_w [DEPTH];

    for (genvar a = 0; a < DEPTH; a++) begin : g_entry
        localparam int VAL = entry_value(a);
        assign table_w[a] = TW'(VAL);
    end

    assign value = table_w[addr];

endmodule

// File: rtl/da_accum.sv
module da_accum
    import da_dot_pkg::*;
#(
    parameter int TW         = 11,
    parameter int RW         = 18,
    parameter int AW         = 20,
    parameter bit HALF_TABLE = 1'b0,
    parameter int SUM_COEF   = 0
) (
    input  logic                 clk,
    input  logic                 rst,
    input  step_ctl_t            ctl,
    input  logic signed [TW-1:0] term,
    input  logic                 sub,
    output logic [RW-1:0]        result,
    output logic                 done
);
    localparam logic signed [AW-1:0] SUM_V = AW'(SUM_COEF);

    logic signed [AW-1:0] acc_q;
    logic signed [AW-1:0] term_ext;
    logic signed [AW-1:0] base;
    logic signed [AW-1:0] acc_next;
    logic signed [AW-1:0] corrected;
    logic signed [AW-1:0] final_v;

    always_comb begin
        term_ext  = {{(AW-TW){term[TW-1]}}, term};
        base      = ctl.first ? '0 : (acc_q <<< 1);
        acc_next  = sub ? (base - term_ext) : (base + term_ext);
        // Offset coding: acc = 2*dot + sum(A); undo at the last step
        corrected = (acc_next - SUM_V) >>> 1;
        final_v   = HALF_TABLE ? corrected : acc_next;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            acc_q  <= '0;
            result <= '0;
            done   <= 1'b0;
        end else begin
            done <= 1'b0;
            if (ctl.valid) acc_q <= acc_next;
            if (ctl.valid && ctl.last) begin
                result <= final_v[RW-1:0];
                done   <= 1'b1;
            end
        end
    end

endmodule

// File: rtl/da_dot_engine.sv
module da_dot_engine
    import da_dot_pkg::*;
#(
    parameter int                   NUM_IN     = 4,
    parameter int                   XW         = 8,
    parameter int                   CW         = 8,
    parameter bit                   HALF_TABLE = 1'b0,
    parameter logic [NUM_IN*CW-1:0] COEFS      = {8'hFB, 8'h7F, 8'h80, 8'h25},
    localparam int                  RW         = CW + XW + $clog2(NUM_IN)
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 start,
    input  logic [NUM_IN*XW-1:0] x_in,
    output logic                 busy,
    output logic                 done,
    output logic [RW-1:0]        result
);
    localparam int TW    = CW + $clog2(NUM_IN) + 1;
    localparam int AW    = RW + 2;
    localparam int ADDRW = HALF_TABLE ? NUM_IN - 1 : NUM_IN;

    function automatic int coef_sum();
        int s;
        s = 0;
        for (int k = 0; k < NUM_IN; k++) s += lane_value(64'(COEFS >> (k * CW)), CW);
        return s;
    endfunction

    localparam int SUM_COEF = coef_sum();

    step_ctl_t            ctl;
    logic                 load;
    logic [NUM_IN-1:0]    slice;
    logic [ADDRW-1:0]     addr;
    logic                 neg;
    logic                 sub;
    logic signed [TW-1:0] term;

    da_step_seq #(.XW(XW)) u_seq (
        .clk   (clk),
        .rst   (rst),
        .start (start),
        .load  (load),
        .busy  (busy),
        .ctl   (ctl)
    );

    da_bit_slicer #(.NUM_IN(NUM_IN), .XW(XW)) u_slicer (
        .clk   (clk),
        .rst   (rst),
        .load  (load),
        .shift (ctl.valid),
        .x_in  (x_in),
        .slice (slice)
    );

    if (HALF_TABLE) begin : g_half
        // Lane 0 bit picks the mirrored half: invert address, negate term
        assign neg  = slice[0];
        assign addr = slice[0] ? ~slice[NUM_IN-1:1] : slice[NUM_IN-1:1];
    end else begin : g_full
        assign neg  = 1'b0;
        assign addr = slice;
    end

    // Sign-bit slice has weight -2^(XW-1): subtract it
    assign sub = ctl.first ^ neg;

    da_coef_rom #(
        .NUM_IN(NUM_IN), .CW(CW), .TW(TW),
        .HALF_TABLE(HALF_TABLE), .COEFS(COEFS)
    ) u_rom (
        .addr  (addr),
        .value (term)
    );

    da_accum #(
        .TW(TW), .RW(RW), .AW(AW),
        .HALF_TABLE(HALF_TABLE), .SUM_COEF(SUM_COEF)
    ) u_acc (
        .clk    (clk),
        .rst    (rst),
        .ctl    (ctl),
        .term   (term),
        .sub    (sub),
        .result (result),
        .done   (done)
    );

endmodule

// File: rtl/da_dot_engine_chk.sv
module da_dot_engine_chk #(
    parameter int XW = 8,
    parameter int RW = 18
) (
    input logic          clk,
    input logic          rst,
    input logic          start,
    input logic          busy,
    input logic          done,
    input logic [RW-1:0] result
);
    localparam int RCW = $clog2(XW + 1) + 1;

    logic [RCW-1:0] run_cnt;

    always_ff @(posedge clk) begin
        if (rst)       run_cnt <= '0;
        else if (busy) run_cnt <= run_cnt + 1'b1;
        else           run_cnt <= '0;
    end

    p_reset_state_r1: assert property (@(posedge clk)
        rst |=> (!busy && !done && result == '0));

    p_launch_r4: assert property (@(posedge clk) disable iff (rst)
        (!busy && start) |=> busy);

    p_done_pulse_r5: assert property (@(posedge clk) disable iff (rst)
        done |=> !done);

    p_done_at_end_r5: assert property (@(posedge clk) disable iff (rst)
        $fell(busy) |-> done);

    p_done_not_busy_r5: assert property (@(posedge clk) disable iff (rst)
        done |-> !busy);

    p_run_length_r9: assert property (@(posedge clk) disable iff (rst)
        done |-> (run_cnt == RCW'(XW)));

    p_no_early_stop_r6: assert property (@(posedge clk) disable iff (rst)
        (busy && run_cnt < RCW'(XW - 1)) |=> busy);

    p_result_hold_r7: assert property (@(posedge clk) disable iff (rst)
        !done |-> $stable(result));

endmodule

bind da_dot_engine da_dot_engine_chk #(.XW(XW), .RW(RW)) u_chk (
    .clk    (clk),
    .rst    (rst),
    .start  (start),
    .busy   (busy),
    .done   (done),
    .result (result)
);

// File: tb/da_dot_engine_tb.sv
module da_dot_engine_tb;
    localparam int CLK_PERIOD = 10;
    localparam int NUM_IN     = 4;
    localparam int XW         = 8;
    localparam int CW         = 8;
    localparam int RW         = CW + XW + $clog2(NUM_IN);
    localparam logic [NUM_IN*CW-1:0] COEFS = {8'hFB, 8'h7F, 8'h80, 8'h25};

    logic                 clk = 1'b0;
    logic                 rst = 1'b1;
    logic                 start = 1'b0;
    logic [NUM_IN*XW-1:0] x_in = '0;
    logic                 busy_p, done_p, busy_h, done_h;
    logic [RW-1:0]        res_p, res_h;

    int checks   = 0;
    int failures = 0;
    int cycles   = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    da_dot_engine #(.NUM_IN(NUM_IN), .XW(XW), .CW(CW), .HALF_TABLE(1'b0), .COEFS(COEFS)) u_dut (
        .clk(clk), .rst(rst), .start(start), .x_in(x_in),
        .busy(busy_p), .done(done_p), .result(res_p)
    );

    da_dot_engine #(.NUM_IN(NUM_IN), .XW(XW), .CW(CW), .HALF_TABLE(1'b1), .COEFS(COEFS)) u_dut_half (
        .clk(clk), .rst(rst), .start(start), .x_in(x_in),
        .busy(busy_h), .done(done_h), .result(res_h)
    );

    task automatic check(input bit ok, input string req, input string what,
                         input longint act, input longint exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    function automatic int expect_dot(input logic [NUM_IN*XW-1:0] xv);
        int s;
        s = 0;
        for (int k = 0; k < NUM_IN; k++)
            s += int'($signed(COEFS[k*CW +: CW])) * int'($signed(xv[k*XW +: XW]));
        return s;
    endfunction

    function automatic int as_int(input logic [RW-1:0] v);
        return int'($signed(v));
    endfunction

    // Runs one operation. If intr_step>0, new operands and a start are
    // presented at that step; both must be ignored (R6).
    task automatic run_op(input logic [NUM_IN*XW-1:0] xv, input string req,
                          input int intr_step, input logic [NUM_IN*XW-1:0] xalt);
        int exp;
        exp = expect_dot(xv);
        @(negedge clk);
        x_in  = xv;
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        check(busy_p && busy_h, "R4", "busy after start", busy_p, 1);
        for (int i = 1; i <= XW; i++) begin
            if (i == intr_step) begin
                x_in  = xalt;
                start = 1'b1;
            end else begin
                start = 1'b0;
            end
            @(negedge clk);
            if (i < XW) begin
                check(!done_p && !done_h, "R5", "done early", done_p, 0);
                check(busy_p && busy_h, "R9", "busy during run", busy_p, 1);
            end
        end
        start = 1'b0;
        check(done_p && done_h, "R5", "done at step XW", done_p, 1);
        check(!busy_p && !busy_h, "R9", "busy cleared at done", busy_p, 0);
        check(as_int(res_p) == exp, req, "plain-table result", as_int(res_p), exp);
        check(as_int(res_h) == exp, (req == "R2") ? "R3" : req, "half-table result",
              as_int(res_h), exp);
        @(negedge clk);
        check(!done_p && !done_h, "R5", "done one cycle", done_p, 0);
    endtask

    function automatic logic [NUM_IN*XW-1:0] fill(input logic [XW-1:0] v);
        logic [NUM_IN*XW-1:0] r;
        for (int k = 0; k < NUM_IN; k++) r[k*XW +: XW] = v;
        return r;
    endfunction

    always @(posedge clk) begin
        cycles++;
        if (cycles > 150000) begin
            failures++;
            checks++;
            $display("FAIL watchdog actual=%0d expected=%0d", cycles, 150000);
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        logic [NUM_IN*XW-1:0] xv;
        logic [RW-1:0] held;
        repeat (3) @(negedge clk);
        // R1 reset state
        check(!busy_p && !busy_h, "R1", "busy in reset", busy_p, 0);
        check(!done_p && !done_h, "R1", "done in reset", done_p, 0);
        check(res_p == '0 && res_h == '0, "R1", "result in reset", as_int(res_p), 0);
        rst = 1'b0;
        @(negedge clk);

        // R8 extreme corners
        run_op(fill(8'h80), "R8", 0, '0);
        run_op(fill(8'h7F), "R8", 0, '0);
        run_op({8'h80, 8'h7F, 8'h80, 8'h7F}, "R8", 0, '0);
        run_op({8'h7F, 8'h80, 8'h7F, 8'h80}, "R8", 0, '0);
        run_op(fill(8'h00), "R2", 0, '0);
        run_op(fill(8'hFF), "R2", 0, '0);

        // R6 start and operand change during a run are ignored
        run_op({8'h12, 8'hE7, 8'h05, 8'h9C}, "R6", 3, fill(8'h55));
        run_op({8'hC3, 8'h21, 8'h7E, 8'h01}, "R6", XW, fill(8'h80));

        // R7 result holds while idle with changing operands
        held = res_p;
        x_in = fill(8'h33);
        repeat (6) @(negedge clk);
        check(res_p == held, "R7", "result held while idle", as_int(res_p), as_int(held));
        check(!done_p && !busy_p, "R7", "no activity without start", done_p, 0);

        // R2/R3 full sweep of lane 0 against fixed other lanes
        for (int v = 0; v < 256; v++) begin
            xv = {8'hA5, 8'h3C, 8'hF0, 8'(v)};
            run_op(xv, "R2", 0, '0);
        end

        // R2/R3 random operand sets
        for (int n = 0; n < 200; n++) begin
            xv = {$urandom, $urandom};
            run_op(xv[NUM_IN*XW-1:0], "R2", 0, '0);
        end

        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule